// File: doc/BRIEF.md
# MDIO Management Master with Completion Interrupt

This block is a memory-mapped master for the two-wire MII management bus. Software runs each PHY access by writing one 32-bit command word that carries the operation, the PHY address, the register number and, for a write, sixteen data bits. The block accepts the word only when idle and then shifts a complete clause-22 frame out on the data line, clocked by a management clock divided down from the system clock. The same register reports whether the bus is busy, whether the last read gave valid data, and the read result in its low half.

Software can learn that a transaction has finished in two ways. It can poll the busy flag, or it can enable the completion cause in a mask register and wait on the interrupt output. The completion cause stays set until software writes a zero to its bit. Writing a one to that bit leaves it unchanged, so an all-ones-but-one write clears exactly one cause.

Top module: `mdio_mgmt_master`

## Requirements
- R1: The command/status word is at byte offset 0x004: bit 26 is the operation (1 read, 0 write), bits 25:21 the register number, bits 20:16 the PHY address, bits 15:0 the write data (or read result); bit 28 is busy and bit 27 is read-valid. Reading it returns the fields of the accepted command.
- R2: A command written while idle is accepted on that clock edge; on the next cycle the word reads busy=1 and read-valid=0.
- R3: A command written while busy=1 is ignored: the fields that read back and the frame on the wire stay those of the running command.
- R4: MDC stays low while idle and, during a frame, has a period of 2*HALF_DIV system clocks.
- R5: A write frame, sent MSB first with every bit driven, is 32 ones, start 01, opcode 01, 5-bit PHY address, 5-bit register, turnaround 10 and 16 data bits; the data line changes only after a falling MDC edge.
- R6: A read frame drives the first 46 bits (opcode 10), releases the line from the turnaround onward, samples 16 data bits on the rising MDC edges after the turnaround, and returns them in bits 15:0 with read-valid=1.
- R7: A frame takes 64 MDC periods; at its end busy returns to 0 and bit 4 of the cause register at offset 0x080 is set.
- R8: A write to the cause register clears bit 4 when that bit is written 0 and keeps it when written 1; a completion in the same cycle wins.
- R9: The mask register at offset 0x084 holds the done enable in bit 4; irq is high exactly when cause bit 4 and mask bit 4 are both 1.
- R10: Completion of a write frame leaves read-valid at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data of the register at bus_addr (combinational) |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | Management data driven toward the PHYs |
| mdio_oe | output | 1 | Output enable for mdio_o; 0 releases the line |
| mdio_i | input | 1 | Management data seen on the line |
| irq | output | 1 | Completion interrupt |

## Verification
Directed transactions cover the extreme field values: PHY address and register number all zero and all ones, write data of zero and of 0xFFFF, and commands written into a running frame. These show the field positions and whether a busy write can leak into the frame. Seeded random transactions then mix reads and writes with random addresses, data and mask settings. Each captured frame is compared bit for bit against a frame built in the bench, and each read result against the value that the bench PHY returns. This separates errors in the shifter, the turnaround release, the sampling edge and the interrupt gating.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  localparam int OFS_CMD   = 'h004;
  localparam int OFS_CAUSE = 'h080;
  localparam int OFS_MASK  = 'h084;

  localparam int BIT_BUSY   = 28;
  localparam int BIT_RVALID = 27;
  localparam int BIT_OP     = 26;
  localparam int REG_LSB    = 21;
  localparam int PHY_LSB    = 16;
  localparam int DONE_BIT   = 4;

  localparam int FRAME_LEN   = 64;
  localparam int DRIVE_RD    = 46;  // bits driven in a read frame
  localparam int RD_DATA_IDX = 48;  // first data bit index in a frame

  typedef struct packed {
    logic        op_rd;
    logic [4:0]  reg_n;
    logic [4:0]  phy;
    logic [15:0] data;
  } mdio_cmd_t;

  function automatic mdio_cmd_t unpack_cmd(input logic [31:0] w);
    mdio_cmd_t c;
    c.op_rd = w[BIT_OP];
    c.reg_n = w[REG_LSB +: 5];
    c.phy   = w[PHY_LSB +: 5];
    c.data  = w[15:0];
    return c;
  endfunction

  function automatic logic [31:0] pack_status(input logic busy, input logic rvalid,
                                              input mdio_cmd_t c);
    logic [31:0] w;
    w = '0;
    w[BIT_BUSY]      = busy;
    w[BIT_RVALID]    = rvalid;
    w[BIT_OP]        = c.op_rd;
    w[REG_LSB +: 5]  = c.reg_n;
    w[PHY_LSB +: 5]  = c.phy;
    w[15:0]          = c.data;
    return w;
  endfunction

  // Whole frame, bit 63 goes out first. Read frames carry filler in the
  // released part; it is never driven.
  function automatic logic [FRAME_LEN-1:0] build_frame(input mdio_cmd_t c);
    logic [1:0]  opc;
    logic [1:0]  ta;
    logic [15:0] pay;
    opc = c.op_rd ? 2'b10 : 2'b01;
    ta  = c.op_rd ? 2'b11 : 2'b10;
    pay = c.op_rd ? 16'hFFFF : c.data;
    return {32'hFFFF_FFFF, 2'b01, opc, c.phy, c.reg_n, ta, pay};
  endfunction

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap      = en && (cnt_q == LAST);
  assign rise_tick = wrap && !mdc;
  assign fall_tick = wrap && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc   <= ~mdc;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r4_half_period: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$stable(mdc)) |-> $past(cnt_q) == LAST)
    else $error("R4 MDC toggled before the half period elapsed");

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_word,
  input  logic        rise_tick,
  input  logic        fall_tick,
  input  logic        mdio_i,
  output logic        busy,
  output logic        rvalid,
  output mdio_cmd_t   cur_cmd,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        done_evt
);
  localparam int IDX_W = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] IDX_REL   = IDX_W'(DRIVE_RD);
  localparam logic [IDX_W-1:0] IDX_DATA  = IDX_W'(RD_DATA_IDX);

  mdio_cmd_t              cmd_q;
  logic [FRAME_LEN-1:0]   sh_q;
  logic [IDX_W-1:0]       idx_q;
  logic [15:0]            rd_sh_q;
  logic                   busy_q;
  logic                   rvalid_q;
  logic                   accept;
  logic                   last_bit;
  logic                   rd_sample;
  mdio_cmd_t              new_cmd;
  logic                   unused_cmd_hi;

  assign new_cmd       = unpack_cmd(cmd_word);
  assign unused_cmd_hi = ^cmd_word[31:27];
  assign accept        = cmd_wr && !busy_q;
  assign last_bit      = (idx_q == IDX_LAST);
  assign done_evt      = busy_q && fall_tick && last_bit;
  assign rd_sample     = busy_q && rise_tick && cmd_q.op_rd && (idx_q >= IDX_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      sh_q     <= '1;
      idx_q    <= '0;
      rd_sh_q  <= '0;
      busy_q   <= 1'b0;
      rvalid_q <= 1'b0;
    end else if (accept) begin
      cmd_q      <= new_cmd;
      if (new_cmd.op_rd) cmd_q.data <= '0;
      sh_q     <= build_frame(new_cmd);
      idx_q    <= '0;
      rd_sh_q  <= '0;
      busy_q   <= 1'b1;
      rvalid_q <= 1'b0;
    end else if (busy_q) begin
      if (rd_sample) rd_sh_q <= {rd_sh_q[14:0], mdio_i};
      if (fall_tick) begin
        if (last_bit) begin
          busy_q <= 1'b0;
          if (cmd_q.op_rd) begin
            cmd_q.data <= rd_sh_q;
            rvalid_q   <= 1'b1;
          end
        end else begin
          idx_q <= idx_q + 1'b1;
          sh_q  <= {sh_q[FRAME_LEN-2:0], 1'b1};
        end
      end
    end
  end

  assign busy    = busy_q;
  assign rvalid  = rvalid_q;
  assign cur_cmd = cmd_q;
  assign mdio_o  = busy_q ? sh_q[FRAME_LEN-1] : 1'b1;
  assign mdio_oe = busy_q && (!cmd_q.op_rd || (idx_q < IDX_REL));

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy_q) |=> (busy_q && !rvalid_q))
    else $error("R2 accepted command did not raise busy");

  a_r3_ignore_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && busy_q) |=> ($stable(cmd_q.op_rd) && $stable(cmd_q.phy) && $stable(cmd_q.reg_n)))
    else $error("R3 command accepted while busy");

  a_r5_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && !$stable(mdio_o)) |-> $past(fall_tick))
    else $error("R5 data changed away from a falling MDC edge");

  a_r10_write_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && !cmd_q.op_rd) |=> !rvalid_q)
    else $error("R10 write completion set read-valid");

endmodule

// File: rtl/mdio_irq_regs.sv
module mdio_irq_regs
  import mdio_mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cause_wr,
  input  logic        mask_wr,
  input  logic [31:0] wdata,
  input  logic        done_evt,
  output logic [31:0] cause_word,
  output logic [31:0] mask_word,
  output logic        irq
);
  logic cause_q;
  logic mask_q;
  logic clr_req;
  logic unused_wdata;

  assign clr_req      = cause_wr && !wdata[DONE_BIT];
  assign unused_wdata = ^{wdata[31:DONE_BIT+1], wdata[DONE_BIT-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q <= 1'b0;
      mask_q  <= 1'b0;
    end else begin
      if (done_evt)     cause_q <= 1'b1;
      else if (clr_req) cause_q <= 1'b0;
      if (mask_wr)      mask_q  <= wdata[DONE_BIT];
    end
  end

  always_comb begin
    cause_word = '0;
    mask_word  = '0;
    cause_word[DONE_BIT] = cause_q;
    mask_word[DONE_BIT]  = mask_q;
  end

  assign irq = |(cause_word & mask_word);

  a_r7_cause_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> cause_q)
    else $error("R7 completion did not set the cause");

  a_r8_keep_unless_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_q && !clr_req) |=> cause_q)
    else $error("R8 cause lost without a zero write");

  a_r8_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !done_evt) |=> !cause_q)
    else $error("R8 zero write did not clear the cause");

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(OFS_CMD);
  localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(OFS_CAUSE);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFS_MASK);

  logic        sel_cmd, sel_cause, sel_mask;
  logic        busy, rvalid, done_evt;
  logic        rise_tick, fall_tick;
  mdio_cmd_t   cur_cmd;
  logic [31:0] cause_word, mask_word;

  assign sel_cmd   = (bus_addr == A_CMD);
  assign sel_cause = (bus_addr == A_CAUSE);
  assign sel_mask  = (bus_addr == A_MASK);

  mdio_clk_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .en(busy),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame_engine u_eng (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr(bus_wr && sel_cmd), .cmd_word(bus_wdata),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
    .busy(busy), .rvalid(rvalid), .cur_cmd(cur_cmd),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done_evt(done_evt)
  );

  mdio_irq_regs u_irq (
    .clk(clk), .rst_n(rst_n),
    .cause_wr(bus_wr && sel_cause), .mask_wr(bus_wr && sel_mask),
    .wdata(bus_wdata), .done_evt(done_evt),
    .cause_word(cause_word), .mask_word(mask_word), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (sel_cmd)   bus_rdata = pack_status(busy, rvalid, cur_cmd);
    if (sel_cause) bus_rdata = cause_word;
    if (sel_mask)  bus_rdata = mask_word;
  end

  a_r4_mdc_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc)
    else $error("R4 MDC active while idle");

  a_r6_released_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cur_cmd.op_rd && $past(busy) && !$past(mdio_oe)) |-> !mdio_oe)
    else $error("R6 line re-driven after release");

endmodule

// File: tb/mdio_mgmt_master_bench.sv
module mdio_mgmt_master_bench;
  localparam int HALF   = 2;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe, irq;
  logic        mdio_i = 1'b1;

  always #(CLK_NS/2) clk = ~clk;

  mdio_mgmt_master #(.ADDR_W(12), .HALF_DIV(HALF)) u_mdio_mgmt_master (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i), .irq(irq)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit mask_on = 1'b0;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // PHY responder
  int          rises = 0;
  int          oe_bits = 0;
  logic [63:0] cap = '0;
  logic [15:0] resp = '0;
  realtime     last_rise = 0;
  realtime     period = 0;

  always @(posedge mdc) begin
    cap = {cap[62:0], (mdio_oe ? mdio_o : mdio_i)};
    if (mdio_oe) oe_bits++;
    rises++;
    period = $realtime - last_rise;
    last_rise = $realtime;
  end

  always @(negedge mdc) begin
    if (rises >= 48 && rises < 64) mdio_i = resp[63 - rises];
    else mdio_i = 1'b1;
  end

  function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] phy,
                                            input logic [4:0] rg, input logic [15:0] d);
    logic [63:0] f;
    f        = '1;
    f[31:30] = 2'b01;
    f[29:28] = rd ? 2'b10 : 2'b01;
    f[27:23] = phy;
    f[22:18] = rg;
    f[17:16] = 2'b10;
    f[15:0]  = d;
    return f;
  endfunction

  function automatic logic [15:0] phy_value(input logic [4:0] phy, input logic [4:0] rg);
    return {rg, phy, 6'h15} ^ 16'hA5C3;
  endfunction

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic run_txn(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                         input logic [15:0] d, input bit poke_busy, input bit m);
    logic [31:0] r;
    logic [31:0] cmd;
    logic [63:0] ef;
    int guard;
    cmd = {5'b0, rd, rg, phy, d};
    ef  = exp_frame(rd, phy, rg, d);
    mask_on = m;
    bus_write(12'h084, m ? 32'h10 : 32'h0);
    bus_read(12'h084, r);
    check(r == (m ? 32'h10 : 32'h0), "R9 mask readback", r, m ? 32'h10 : 32'h0);
    resp = phy_value(phy, rg); rises = 0; oe_bits = 0;
    bus_write(12'h004, cmd);
    bus_read(12'h004, r);
    check(r[28] == 1'b1 && r[27] == 1'b0, "R2 busy set and valid cleared", r, 32'h1000_0000);
    if (poke_busy) begin
      bus_write(12'h004, cmd ^ 32'h07FF_FFFF);
      bus_read(12'h004, r);
      check(r[26:16] == cmd[26:16], "R3 busy write ignored", r[26:16], cmd[26:16]);
    end
    guard = 0;
    do begin
      bus_read(12'h004, r);
      guard++;
    end while (r[28] && guard < 5000);
    check(!r[28], "R7 busy clears", r, 0);
    check(rises == 64, "R7 frame of 64 MDC periods", rises, 64);
    check(period == 2 * HALF * CLK_NS, "R4 MDC period", 64'(int'(period)), 2 * HALF * CLK_NS);
    if (!rd) begin
      check(cap == ef, "R5 write frame bits", cap, ef);
      check(oe_bits == 64, "R5 write frame driven", oe_bits, 64);
      check(r[27] == 1'b0 && r[15:0] == d, "R10 write leaves valid low", r, {16'h0, d});
    end else begin
      check(cap[63:18] == ef[63:18], "R6 read header bits", cap, ef);
      check(oe_bits == 46, "R6 line released at turnaround", oe_bits, 46);
      check(r[27] == 1'b1 && r[15:0] == resp, "R6 read data and valid", r, {16'h0800, resp});
    end
    check(r[26:16] == cmd[26:16], "R1 command fields readback", r[26:16], cmd[26:16]);
    bus_read(12'h080, r);
    check(r == 32'h10, "R7 done cause set", r, 32'h10);
    check(irq == mask_on, "R9 irq follows mask", irq, mask_on);
    bus_write(12'h080, 32'hFFFF_FFFF);
    bus_read(12'h080, r);
    check(r == 32'h10, "R8 ones keep cause", r, 32'h10);
    bus_write(12'h080, ~32'h10);
    bus_read(12'h080, r);
    check(r == 32'h0, "R8 zero clears cause", r, 0);
    check(irq == 1'b0, "R9 irq low after clear", irq, 0);
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    bus_read(12'h004, r);
    check(r == 0, "R1 reset command word", r, 0);
    bus_read(12'h080, r);
    check(r == 0, "R7 reset cause", r, 0);
    bus_read(12'h084, r);
    check(r == 0, "R9 reset mask", r, 0);
    check(mdc == 0 && irq == 0 && mdio_oe == 0, "R4 idle outputs", {mdc, irq, mdio_oe}, 0);

    run_txn(1'b0, 5'd0,  5'd0,  16'h0000, 1'b0, 1'b1);
    run_txn(1'b1, 5'd31, 5'd31, 16'h0000, 1'b0, 1'b1);
    run_txn(1'b0, 5'd31, 5'd31, 16'hFFFF, 1'b1, 1'b0);
    run_txn(1'b1, 5'd0,  5'd1,  16'h1234, 1'b1, 1'b1);
    run_txn(1'b0, 5'd5,  5'd2,  16'h8001, 1'b0, 1'b0);
    for (int i = 0; i < 16; i++) begin
      run_txn(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom),
              1'($urandom), 1'($urandom));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule